// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the master side of a three-wire serial link to a 12-bit sampling converter. A start request pulls the active-low chip-select down, and that falling edge begins a conversion in the converter. The block then produces exactly sixteen serial clock pulses in mode 0: the clock idles low, the converter changes its data line on falling edges, and the block samples that line on rising edges. From the sixteen received bits it strips a three-bit all-ones marker and a channel bit, and keeps the twelve result bits.

When the sixteenth falling edge has been produced, chip-select returns high. In that same cycle the block shows the result, the channel bit and a marker-check flag, with a one-cycle done strobe. Chip-select then stays high for a minimum gap that is derived from the system clock period, so that at least 60 ns pass before the next conversion can start. A start that arrives while a frame or a gap is in progress is held until the gap ends. An abort input ends a frame early, with no result.

The serial clock half-period and the gap are both counted in system-clock cycles. The two timing parameters and the field widths are all set by parameters.

Top module: `adc_frame_reader`

## Requirements
- R1: While `csn_o` is high, `sclk_o` is low, and `csn_o` only falls while `sclk_o` is low.
- R2: A start accepted when the block is idle and the gap has expired drives `csn_o` low on the next clock edge. The first rising `sclk_o` follows HALF_DIV cycles later, and each high and low phase of `sclk_o` lasts HALF_DIV cycles.
- R3: Each frame has exactly FRAME_W = HDR_W+1+DATA_W (16) rising `sclk_o` edges, never more. `sdata_i` is sampled on each rising edge, and the first bit received is the most significant bit of the frame.
- R4: `csn_o` rises on the same clock edge that produces the last falling `sclk_o` edge. `done_o` is high for exactly that one cycle.
- R5: Received bits 5 to 16 (in arrival order) appear on `result_o` with the first of them as the MSB, and bit 4 appears on `chan_o`. These outputs hold their values until the next completed frame.
- R6: `frame_err_o` is 1 when any of received bits 1 to 3 is 0 and 0 when all three are 1. In both cases the result and channel are still reported.
- R7: Between any rise of `csn_o` and its next fall, including the first fall after reset, `csn_o` stays high for at least GAP_CYC = ceil(MIN_GAP_PS / CLK_PERIOD_PS) cycles.
- R8: `abort_i` during a frame drives `csn_o` high and `sclk_o` low on the next edge. No `done_o` follows, and the result outputs keep their values. `abort_i` has no effect on the pins when no frame is running and no start is held.
- R9: Starts that arrive during a frame or during the gap collapse into one held request. That request launches exactly one new frame once the gap has expired.
- R10: `abort_i` discards a held start request, so no frame follows it.
- R11: During and after reset, `csn_o`=1, `sclk_o`=0, `done_o`=0, `result_o`=0, `chan_o`=0 and `frame_err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion-and-readout cycle |
| abort_i | input | 1 | End the current frame and drop any held request |
| sdata_i | input | 1 | Serial data from the converter |
| csn_o | output | 1 | Active-low chip-select; its falling edge starts conversion |
| sclk_o | output | 1 | Serial clock, idles low |
| done_o | output | 1 | One-cycle strobe when a frame completes |
| result_o | output | DATA_W (12) | Conversion result |
| chan_o | output | 1 | Channel identifier bit from the frame |
| frame_err_o | output | 1 | Marker bits were not all ones |

## Verification
The bench sets HALF_DIV to 2, which keeps each frame to about 64 cycles. That leaves room for back-to-back, aborted and held-request sequences within the run. The gap limits stay at a 8000 ps clock and 60000 ps. Because 7.5 cycles must round up, GAP_CYC becomes 8, so the rounding in the gap calculation is exercised. A converter model in the bench shifts out frames with a good and a corrupted marker, different channel bits and different data patterns. A monitor measures the phase lengths, the count of rising edges and the chip-select high time against those values.

// File: rtl/adcfr_pkg.sv
package adcfr_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE   = 1'b0,
        SEQ_ACTIVE = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_evt_t;

    // Cycles needed to cover gap_ps with a clock of period_ps, rounded up, at least one.
    function automatic int unsigned gap_cycles(input int unsigned period_ps,
                                               input int unsigned gap_ps);
        int unsigned n;
        n = (gap_ps + period_ps - 1) / period_ps;
        return (n < 1) ? 1 : n;
    endfunction

endpackage

// File: rtl/adcfr_sclk_gen.sv
module adcfr_sclk_gen
    import adcfr_pkg::*;
#(
    parameter int unsigned HALF_DIV = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    output logic      sclk_o,
    output sclk_evt_t evt
);

    logic tick;

    generate
        if (HALF_DIV <= 1) begin : g_div1
            assign tick = run;
        end else begin : g_divn
            localparam int unsigned CW = $clog2(HALF_DIV);
            logic [CW-1:0] half_cnt;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    half_cnt <= '0;
                end else if (half_cnt == CW'(HALF_DIV - 1)) begin
                    half_cnt <= '0;
                end else begin
                    half_cnt <= half_cnt + 1'b1;
                end
            end

            assign tick = run && (half_cnt == CW'(HALF_DIV - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sclk_o <= 1'b0;
        end else if (tick) begin
            sclk_o <= ~sclk_o;
        end
    end

    always_comb begin
        evt.rise = tick && !sclk_o;
        evt.fall = tick &&  sclk_o;
    end

    // R2: the clock may only be high while the generator is running
    p_sclk_stops_r2: assert property (@(posedge clk) disable iff (rst)
        !run |=> !sclk_o);

endmodule

// File: rtl/adcfr_shifter.sv
module adcfr_shifter #(
    parameter int unsigned FRAME_W = 16,
    localparam int unsigned CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               shift_en,
    input  logic               sdata_i,
    output logic [FRAME_W-1:0] word_o,
    output logic [CNT_W-1:0]   count_o
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word_o  <= '0;
            count_o <= '0;
        end else if (shift_en) begin
            word_o  <= {word_o[FRAME_W-2:0], sdata_i};
            count_o <= count_o + 1'b1;
        end
    end

    // R3: the sequencer never asks for a bit beyond the frame length
    p_no_overshift_r3: assert property (@(posedge clk) disable iff (rst)
        shift_en |-> (count_o < CNT_W'(FRAME_W)));

endmodule

// File: rtl/adcfr_gap_timer.sv
module adcfr_gap_timer #(
    parameter int unsigned GAP_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired_o
);

    localparam int unsigned CW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

    logic [CW-1:0] cnt;
    logic          running;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt     <= '0;
            running <= 1'b1;
        end else if (running) begin
            if (cnt == CW'(GAP_CYC - 1)) begin
                running <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign expired_o = !running;

    // R7: a freshly loaded gap is never reported as expired
    p_gap_restart_r7: assert property (@(posedge clk) disable iff (rst)
        load |=> !expired_o);

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adcfr_pkg::*;
#(
    parameter int unsigned DATA_W        = 12,
    parameter int unsigned HDR_W         = 3,
    parameter int unsigned HALF_DIV      = 4,
    parameter int unsigned CLK_PERIOD_PS = 8000,
    parameter int unsigned MIN_GAP_PS    = 60000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic              sdata_i,
    output logic              csn_o,
    output logic              sclk_o,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o,
    output logic              chan_o,
    output logic              frame_err_o
);

    localparam int unsigned FRAME_W = HDR_W + 1 + DATA_W;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
    localparam int unsigned GAP_CYC = gap_cycles(CLK_PERIOD_PS, MIN_GAP_PS);
    localparam int unsigned HI_W    = $clog2(GAP_CYC + 2);

    seq_state_e         st;
    logic               pend;
    logic               gap_expired;
    logic               launch, finish, stop, run;
    sclk_evt_t          evt;
    logic [FRAME_W-1:0] word;
    logic [CNT_W-1:0]   bit_cnt;

    assign launch = (st == SEQ_IDLE) && gap_expired && (pend || start_i) && !abort_i;
    assign run    = (st == SEQ_ACTIVE) && !abort_i;
    assign stop   = (st == SEQ_ACTIVE) && abort_i;
    assign finish = run && evt.fall && (bit_cnt == CNT_W'(FRAME_W));

    adcfr_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .sclk_o (sclk_o),
        .evt    (evt)
    );

    adcfr_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clear    (launch),
        .shift_en (run && evt.rise),
        .sdata_i  (sdata_i),
        .word_o   (word),
        .count_o  (bit_cnt)
    );

    adcfr_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk       (clk),
        .rst       (rst),
        .load      (finish || stop),
        .expired_o (gap_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SEQ_IDLE;
            pend  <= 1'b0;
            csn_o <= 1'b1;
        end else begin
            if (abort_i || launch) begin
                pend <= 1'b0;
            end else if (start_i) begin
                pend <= 1'b1;
            end

            if (launch) begin
                st    <= SEQ_ACTIVE;
                csn_o <= 1'b0;
            end else if (finish || stop) begin
                st    <= SEQ_IDLE;
                csn_o <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o      <= 1'b0;
            result_o    <= '0;
            chan_o      <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            done_o <= finish;
            if (finish) begin
                result_o    <= word[DATA_W-1:0];
                chan_o      <= word[DATA_W];
                frame_err_o <= ~&word[FRAME_W-1 -: HDR_W];
            end
        end
    end

    // Cycles chip-select has been high, saturating; used only by the checks below
    logic [HI_W-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
        end else if (!csn_o) begin
            hi_cnt <= '0;
        end else if (hi_cnt != {HI_W{1'b1}}) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    p_sclk_idle_r1: assert property (@(posedge clk) disable iff (rst)
        csn_o |-> !sclk_o);

    p_gap_min_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(csn_o) |-> (hi_cnt >= HI_W'(GAP_CYC)));

    p_done_edge_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $rose(csn_o));

    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_abort_stop_r8: assert property (@(posedge clk) disable iff (rst)
        (st == SEQ_ACTIVE && abort_i) |=> (csn_o && !sclk_o && !done_o));

    p_result_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o));

endmodule

// File: tb/adc_frame_reader_tb_top.sv
`timescale 1ns/1ps
module adc_frame_reader_tb_top;

    localparam int HALF    = 2;
    localparam int GAP_EXP = (60000 + 8000 - 1) / 8000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        abort_i = 1'b0;
    logic        sdata = 1'b0;
    logic        csn_o, sclk_o, done_o, chan_o, frame_err_o;
    logic [11:0] result_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    adc_frame_reader #(
        .DATA_W(12), .HDR_W(3), .HALF_DIV(HALF),
        .CLK_PERIOD_PS(8000), .MIN_GAP_PS(60000)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i),
        .sdata_i(sdata), .csn_o(csn_o), .sclk_o(sclk_o), .done_o(done_o),
        .result_o(result_o), .chan_o(chan_o), .frame_err_o(frame_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Converter model: first bit ready at chip-select fall, next bit after each falling clock
    logic [15:0] slave_word = 16'h0;
    int          sidx = 0;
    always @(negedge csn_o) begin
        sidx  = 15;
        sdata = slave_word[15];
    end
    always @(negedge sclk_o) begin
        if (!csn_o) begin
            sidx  = sidx - 1;
            sdata = (sidx >= 0) ? slave_word[sidx] : 1'b0;
        end
    end

    // Monitor, sampled on the falling system clock
    logic prev_csn = 1'b1, prev_sclk = 1'b0;
    int   rises = 0, lat = 0, hi_len = 0, hi_run = 0, lo_run = 0;
    int   done_cnt = 0, frame_cnt = 0, r1_viol = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (csn_o && sclk_o) r1_viol++;
            if (prev_csn && !csn_o) begin
                frame_cnt++;
                chk(!sclk_o, "R1 sclk low at cs fall", sclk_o, 0);
                chk(hi_len >= GAP_EXP, "R7 cs high gap", hi_len, GAP_EXP);
                rises = 0; lat = 0; hi_run = 0; lo_run = 0;
            end
            if (!csn_o) begin
                if (!prev_sclk && sclk_o) begin
                    if (rises == 0) chk(lat == HALF, "R2 first rise latency", lat, HALF);
                    else chk(lo_run == HALF, "R2 low phase", lo_run, HALF);
                    rises++;
                    hi_run = 0;
                end
                if (prev_sclk && !sclk_o) chk(hi_run == HALF, "R2 high phase", hi_run, HALF);
                if (sclk_o) hi_run++;
                else begin
                    if (rises == 0) lat++;
                    if (!prev_sclk || rises == 0) lo_run = (prev_sclk ? 0 : lo_run) + 1;
                    else lo_run = 1;
                end
            end
            if (done_o) begin
                done_cnt++;
                chk(csn_o && !prev_csn, "R4 cs rises with done", csn_o, 1);
                chk(rises == 16, "R3 rising edges per frame", rises, 16);
            end
            hi_len = csn_o ? hi_len + 1 : 0;
        end
        prev_csn  = csn_o;
        prev_sclk = sclk_o;
    end

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic pulse_abort();
        @(negedge clk) abort_i = 1'b1;
        @(negedge clk) abort_i = 1'b0;
    endtask

    task automatic wait_done(output bit got);
        got = 1'b0;
        for (int i = 0; i < 400 && !got; i++) begin
            @(negedge clk);
            if (done_o) got = 1'b1;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(csn_o == 1'b1, "R11 reset csn", csn_o, 1);
        chk(sclk_o == 1'b0 && done_o == 1'b0, "R11 reset sclk/done", {sclk_o, done_o}, 0);
        chk(result_o == 12'h0 && !chan_o && !frame_err_o, "R11 reset outputs",
            result_o, 0);
    endtask

    task automatic t_frame(input logic [15:0] w, input string tag);
        bit got;
        slave_word = w;
        pulse_start();
        wait_done(got);
        chk(got, {"R4 done seen ", tag}, got, 1);
        chk(result_o == w[11:0], {"R5 result ", tag}, result_o, w[11:0]);
        chk(chan_o == w[12], {"R5 channel ", tag}, chan_o, w[12]);
        chk(frame_err_o == (w[15:13] != 3'b111), {"R6 marker flag ", tag},
            frame_err_o, (w[15:13] != 3'b111));
        @(negedge clk);
        chk(!done_o, {"R4 done one cycle ", tag}, done_o, 0);
        repeat (4) @(negedge clk);
        chk(result_o == w[11:0], {"R5 result held ", tag}, result_o, w[11:0]);
        repeat (GAP_EXP + 2) @(negedge clk);
    endtask

    task automatic t_abort_mid();
        int d0, f0;
        logic [11:0] r0;
        r0 = result_o; d0 = done_cnt;
        slave_word = 16'hE777;
        pulse_start();
        repeat (9) @(negedge clk);
        pulse_abort();
        chk(csn_o && !sclk_o, "R8 abort stops frame", {csn_o, sclk_o}, 2);
        f0 = frame_cnt;
        repeat (60) @(negedge clk);
        chk(done_cnt == d0, "R8 no done after abort", done_cnt, d0);
        chk(result_o == r0, "R8 result kept after abort", result_o, r0);
        chk(frame_cnt == f0, "R8 no restart after abort", frame_cnt, f0);
    endtask

    task automatic t_abort_idle();
        int d0, f0;
        logic [11:0] r0;
        r0 = result_o; d0 = done_cnt; f0 = frame_cnt;
        pulse_abort();
        repeat (20) @(negedge clk);
        chk(csn_o && frame_cnt == f0 && done_cnt == d0, "R8 idle abort ignored",
            frame_cnt, f0);
        chk(result_o == r0, "R8 idle abort keeps result", result_o, r0);
    endtask

    task automatic t_held_start();
        bit got;
        int d0;
        d0 = done_cnt;
        slave_word = 16'hF0F1;
        pulse_start();
        repeat (5) @(negedge clk);
        pulse_start();
        repeat (3) @(negedge clk);
        pulse_start();
        wait_done(got);
        chk(result_o == 12'h0F1 && chan_o == 1'b1, "R9 first frame", result_o, 12'h0F1);
        slave_word = 16'hE3C2;
        wait_done(got);
        chk(got, "R9 held start launches", got, 1);
        chk(result_o == 12'h3C2 && !chan_o, "R9 second frame", result_o, 12'h3C2);
        repeat (100) @(negedge clk);
        chk(done_cnt == d0 + 2, "R9 requests collapse", done_cnt, d0 + 2);
    endtask

    task automatic t_abort_drops();
        int f0, d0;
        slave_word = 16'hE001;
        pulse_start();
        repeat (5) @(negedge clk);
        pulse_start();
        repeat (5) @(negedge clk);
        pulse_abort();
        f0 = frame_cnt; d0 = done_cnt;
        repeat (60) @(negedge clk);
        chk(frame_cnt == f0 && done_cnt == d0, "R10 held start dropped", frame_cnt, f0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_frame(16'hFA5C, "hdr ok ch1");
        t_frame(16'hE801, "hdr ok ch0");
        t_frame(16'hBFFF, "hdr bad");
        t_frame(16'h0000, "all zero");
        t_abort_mid();
        t_frame(16'hF123, "after abort");
        t_abort_idle();
        t_held_start();
        t_abort_drops();
        t_frame(16'hECAB, "final");
        chk(r1_viol == 0, "R1 sclk low while cs high", r1_viol, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule